// File: doc/BRIEF.md
# Message-Signaled Interrupt Bridge Pair

This block holds both ends of an interrupt path in which an interrupt travels as an ordinary 32-bit bus write rather than as a dedicated wire. The source end belongs to a device adapter. Software programs it with a destination address and a vector value. Each device event is then turned into one write of the vector to that address, issued on a request/acknowledge write-master port. The sink end sits in the host bridge. It watches incoming bus writes for four request-register addresses at offsets 0x800, 0x804, 0x808 and 0x80C above its base. A hit on one of them stores the written word as that channel's vector and marks the channel pending. The OR of the pending flags drives a single host interrupt line.

In use, the host programs the source with the address of one sink channel and a vector. The bus fabric, which is outside the block, carries the write from the source master port to the sink write port. Host software reads a channel's vector through a select input, and clears that channel with a write-1-to-clear mask.

The source end is a three-state machine. SRC_IDLE goes to SRC_SEND when an event is pending and the destination address is non-zero. SRC_IDLE goes to SRC_HOLD when an event is pending and the destination address is zero. SRC_HOLD goes to SRC_SEND once the destination address becomes non-zero. SRC_SEND goes back to SRC_IDLE on acknowledge. Each sink channel has its own state machine. CH_IDLE goes to CH_PEND on a hit. CH_PEND goes to CH_OVR on another hit, and back to CH_IDLE on a clear. CH_OVR goes to CH_IDLE on a clear. A hit arriving together with a clear takes CH_PEND or CH_OVR to CH_PEND.

Top module: `msg_irq_pair`

## Requirements
- R1: After reset, mw_req, host_pend, host_ovr and host_irq are all zero, and the destination and vector registers are zero.
- R2: cfg_wr with cfg_sel=0 loads the destination address register from cfg_data. cfg_wr with cfg_sel=1 loads the vector register from cfg_data.
- R3: A write carries mw_addr equal to the destination register and mw_data equal to the vector register, both taken when the write starts. Both stay stable while mw_req is high and mw_ack is low.
- R4: Each event produces exactly one write. mw_req is low in the cycle after the cycle in which mw_req and mw_ack are both high.
- R5: While the destination register is zero, an event stays pending and no write is issued. Writing a non-zero destination then issues the write.
- R6: An event that arrives while a write is outstanding, including in the acknowledge cycle, causes one further write after the current one completes.
- R7: A sink write (sw_valid high) to BASE+0x800+4*n, for n from 0 to 3, stores sw_data as the vector of channel n and sets host_pend[n]. host_rd_vec shows the vector of the channel chosen by host_rd_sel.
- R8: Sink writes whose address lies outside BASE+0x800 to BASE+0x80F, or whose address is not a multiple of 4, change no pending, overrun or vector state.
- R9: host_clr_we with host_clr_mask clears host_pend[n] and host_ovr[n] for every mask bit n that is 1. Bits with a mask value of 0 are left unchanged.
- R10: A hit on a channel that is already pending sets host_ovr for that channel and keeps the newer vector.
- R11: A hit and a clear on the same channel in the same cycle leave that channel pending, with overrun clear and the new vector stored.
- R12: host_irq is the OR of the four host_pend bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 1 | Device interrupt event, one-cycle pulse |
| cfg_wr | input | 1 | Source configuration write strobe |
| cfg_sel | input | 1 | 0 selects the destination register, 1 selects the vector register |
| cfg_data | input | 32 | Configuration write data |
| mw_req | output | 1 | Master write request |
| mw_addr | output | 32 | Master write address |
| mw_data | output | 32 | Master write data (vector) |
| mw_ack | input | 1 | Master write acknowledge |
| sw_valid | input | 1 | Sink bus write strobe |
| sw_addr | input | 32 | Sink bus write address |
| sw_data | input | 32 | Sink bus write data |
| host_rd_sel | input | 2 | Channel selected for vector readback |
| host_rd_vec | output | 32 | Stored vector of the selected channel |
| host_pend | output | 4 | Per-channel pending flags |
| host_ovr | output | 4 | Per-channel overrun flags |
| host_clr_we | input | 1 | Clear strobe |
| host_clr_mask | input | 4 | Write-1-to-clear mask |
| host_irq | output | 1 | Host interrupt, OR of the pending flags |

## Verification
The assertions assume that mw_ack is raised only while mw_req is high and lasts one cycle. They assume that evt_in is a single-cycle pulse, and that a pending flag can fall only because of a clear, never because of a bus write. The bench keeps to these assumptions. Its responder raises the acknowledge only after it has seen the request, and drops it after one handshake cycle. It forwards each acknowledged write to the sink port one cycle later. It drives sink writes and clears only from its single stimulus sequence, so no two transactions on the same port overlap.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE,
        SRC_HOLD,
        SRC_SEND
    } src_state_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_PEND,
        CH_OVR
    } ch_state_e;

    localparam int REQ_STRIDE = 4;

endpackage

// File: rtl/msg_irq_src.sv
module msg_irq_src
    import msg_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt_in,
    input  logic         cfg_wr,
    input  logic         cfg_sel,
    input  logic [W-1:0] cfg_data,
    output logic         mw_req,
    output logic [W-1:0] mw_addr,
    output logic [W-1:0] mw_data,
    input  logic         mw_ack
);

    src_state_e   state_q, state_d;
    logic [W-1:0] tgt_q, vec_q;
    logic [W-1:0] addr_q, data_q;
    logic         pend_q, again_q;
    logic         snap;
    logic         ack_done;

    // software-visible destination and vector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
            vec_q <= '0;
        end else if (cfg_wr) begin
            if (cfg_sel) vec_q <= cfg_data;
            else         tgt_q <= cfg_data;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    // next state and snapshot strobe
    always_comb begin
        state_d = state_q;
        snap    = 1'b0;
        unique case (state_q)
            SRC_IDLE: begin
                if (pend_q) begin
                    if (tgt_q != '0) begin
                        state_d = SRC_SEND;
                        snap    = 1'b1;
                    end else begin
                        state_d = SRC_HOLD;
                    end
                end
            end
            SRC_HOLD: begin
                if (tgt_q != '0) begin
                    state_d = SRC_SEND;
                    snap    = 1'b1;
                end
            end
            SRC_SEND: begin
                if (mw_ack) state_d = SRC_IDLE;
            end
            default: state_d = SRC_IDLE;
        endcase
    end

    assign ack_done = (state_q == SRC_SEND) && mw_ack;

    // event latch: pending drops only on acknowledge, unless re-armed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            again_q <= 1'b0;
        end else if (ack_done) begin
            pend_q  <= again_q | evt_in;
            again_q <= 1'b0;
        end else begin
            if (evt_in) pend_q <= 1'b1;
            if (evt_in && state_q == SRC_SEND) again_q <= 1'b1;
        end
    end

    // address and vector captured when a write starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (snap) begin
            addr_q <= tgt_q;
            data_q <= vec_q;
        end
    end

    // outputs
    always_comb begin
        mw_req  = (state_q == SRC_SEND);
        mw_addr = addr_q;
        mw_data = data_q;
    end

endmodule

// File: rtl/msg_irq_dec.sv
module msg_irq_dec
    import msg_irq_pkg::*;
#(
    parameter int          W       = 32,
    parameter int          NUM_CH  = 4,
    parameter logic [W-1:0] BASE   = 32'h0002_0000,
    parameter int          REQ_OFF = 'h800
) (
    input  logic              wr_valid,
    input  logic [W-1:0]      wr_addr,
    output logic [NUM_CH-1:0] hit
);

    localparam int           CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [W-1:0] WIN_LO = BASE + W'(REQ_OFF);
    localparam logic [W-1:0] WIN_SZ = W'(NUM_CH * REQ_STRIDE);

    logic [W-1:0] offset;
    logic         in_win;

    assign offset = wr_addr - WIN_LO;
    assign in_win = wr_valid && (offset < WIN_SZ) && (offset[1:0] == 2'b00);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign hit[i] = in_win && (offset[CH_W+1:2] == CH_W'(i));
    end

endmodule

// File: rtl/msg_irq_chan.sv
module msg_irq_chan
    import msg_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  logic         clr,
    input  logic [W-1:0] wdata,
    output logic         pend,
    output logic         ovr,
    output logic [W-1:0] vec
);

    ch_state_e    state_q, state_d;
    logic [W-1:0] vec_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (hit) state_d = CH_PEND;
            end
            CH_PEND: begin
                if (hit && clr)  state_d = CH_PEND;
                else if (clr)    state_d = CH_IDLE;
                else if (hit)    state_d = CH_OVR;
            end
            CH_OVR: begin
                if (hit && clr)  state_d = CH_PEND;
                else if (clr)    state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // newest vector always kept
    always_ff @(posedge clk) begin
        if (!rst_n)   vec_q <= '0;
        else if (hit) vec_q <= wdata;
    end

    // outputs
    always_comb begin
        pend = (state_q != CH_IDLE);
        ovr  = (state_q == CH_OVR);
        vec  = vec_q;
    end

endmodule

// File: rtl/msg_irq_sink.sv
module msg_irq_sink
    import msg_irq_pkg::*;
#(
    parameter int           W       = 32,
    parameter int           NUM_CH  = 4,
    parameter logic [W-1:0] BASE    = 32'h0002_0000,
    parameter int           REQ_OFF = 'h800
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_valid,
    input  logic [W-1:0]        sw_addr,
    input  logic [W-1:0]        sw_data,
    input  logic [CH_W-1:0]     rd_sel,
    output logic [W-1:0]        rd_vec,
    output logic [NUM_CH-1:0]   pend,
    output logic [NUM_CH-1:0]   ovr,
    input  logic                clr_we,
    input  logic [NUM_CH-1:0]   clr_mask,
    output logic                irq
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0] hit;
    logic [W-1:0]      vec_a [NUM_CH];

    msg_irq_dec #(
        .W       (W),
        .NUM_CH  (NUM_CH),
        .BASE    (BASE),
        .REQ_OFF (REQ_OFF)
    ) u_dec (
        .wr_valid (sw_valid),
        .wr_addr  (sw_addr),
        .hit      (hit)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        msg_irq_chan #(.W(W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit[i]),
            .clr   (clr_we && clr_mask[i]),
            .wdata (sw_data),
            .pend  (pend[i]),
            .ovr   (ovr[i]),
            .vec   (vec_a[i])
        );
    end

    assign rd_vec = vec_a[rd_sel];
    assign irq    = |pend;

endmodule

// File: rtl/msg_irq_pair.sv
module msg_irq_pair
    import msg_irq_pkg::*;
#(
    parameter int           W       = 32,
    parameter int           NUM_CH  = 4,
    parameter logic [W-1:0] BASE    = 32'h0002_0000,
    parameter int           REQ_OFF = 'h800,
    localparam int          CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_in,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [W-1:0]      cfg_data,
    output logic              mw_req,
    output logic [W-1:0]      mw_addr,
    output logic [W-1:0]      mw_data,
    input  logic              mw_ack,
    input  logic              sw_valid,
    input  logic [W-1:0]      sw_addr,
    input  logic [W-1:0]      sw_data,
    input  logic [CH_W-1:0]   host_rd_sel,
    output logic [W-1:0]      host_rd_vec,
    output logic [NUM_CH-1:0] host_pend,
    output logic [NUM_CH-1:0] host_ovr,
    input  logic              host_clr_we,
    input  logic [NUM_CH-1:0] host_clr_mask,
    output logic              host_irq
);

    msg_irq_src #(.W(W)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .cfg_wr   (cfg_wr),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .mw_req   (mw_req),
        .mw_addr  (mw_addr),
        .mw_data  (mw_data),
        .mw_ack   (mw_ack)
    );

    msg_irq_sink #(
        .W       (W),
        .NUM_CH  (NUM_CH),
        .BASE    (BASE),
        .REQ_OFF (REQ_OFF)
    ) u_sink (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_valid (sw_valid),
        .sw_addr  (sw_addr),
        .sw_data  (sw_data),
        .rd_sel   (host_rd_sel),
        .rd_vec   (host_rd_vec),
        .pend     (host_pend),
        .ovr      (host_ovr),
        .clr_we   (host_clr_we),
        .clr_mask (host_clr_mask),
        .irq      (host_irq)
    );

endmodule

// File: rtl/msg_irq_pair_chk.sv
module msg_irq_pair_chk #(
    parameter int W      = 32,
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mw_req,
    input logic              mw_ack,
    input logic [W-1:0]      mw_addr,
    input logic [W-1:0]      mw_data,
    input logic              sw_valid,
    input logic [NUM_CH-1:0] host_pend,
    input logic [NUM_CH-1:0] host_ovr,
    input logic              host_clr_we,
    input logic              host_irq
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!mw_req && host_pend == '0 && host_ovr == '0));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_req && !mw_ack) |=> (mw_req && $stable(mw_addr) && $stable(mw_data)));

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_req && mw_ack) |=> !mw_req);

    // R5
    no_null_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mw_req |-> (mw_addr != '0));

    // R9
    pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(host_pend) & ~host_pend) != '0) |-> $past(host_clr_we));

    // R10
    ovr_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_ovr & ~host_pend) == '0));

    // R12
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> $past(sw_valid));

endmodule

bind msg_irq_pair msg_irq_pair_chk #(.W(W), .NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_msg_irq_pair.sv
module test_msg_irq_pair;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [31:0] CH0 = 32'h0002_0800;
    localparam logic [31:0] CH1 = 32'h0002_0804;
    localparam logic [31:0] CH2 = 32'h0002_0808;
    localparam logic [31:0] CH3 = 32'h0002_080C;

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
    } wr_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_in = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        mw_req;
    logic [31:0] mw_addr, mw_data;
    logic        mw_ack = 1'b0;
    logic        sw_valid = 1'b0;
    logic [31:0] sw_addr = '0;
    logic [31:0] sw_data = '0;
    logic [1:0]  host_rd_sel = '0;
    logic [31:0] host_rd_vec;
    logic [3:0]  host_pend, host_ovr;
    logic        host_clr_we = 1'b0;
    logic [3:0]  host_clr_mask = '0;
    logic        host_irq;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    wr_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    msg_irq_pair i_msg_irq_pair (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_in        (evt_in),
        .cfg_wr        (cfg_wr),
        .cfg_sel       (cfg_sel),
        .cfg_data      (cfg_data),
        .mw_req        (mw_req),
        .mw_addr       (mw_addr),
        .mw_data       (mw_data),
        .mw_ack        (mw_ack),
        .sw_valid      (sw_valid),
        .sw_addr       (sw_addr),
        .sw_data       (sw_data),
        .host_rd_sel   (host_rd_sel),
        .host_rd_vec   (host_rd_vec),
        .host_pend     (host_pend),
        .host_ovr      (host_ovr),
        .host_clr_we   (host_clr_we),
        .host_clr_mask (host_clr_mask),
        .host_irq      (host_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(input logic sel, input logic [31:0] val);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_data = val;
        tick();
        cfg_wr = 1'b0;
    endtask

    // driver: pushes the expected write, then pulses the event
    task automatic raise_event(input logic [31:0] a, input logic [31:0] d);
        wr_t it;
        it.a = a; it.d = d;
        exp_q.push_back(it);
        evt_in = 1'b1;
        tick();
        evt_in = 1'b0;
    endtask

    task automatic wait_req();
        do @(negedge clk); while (!mw_req);
    endtask

    // responder: acknowledge after a delay, forward the write to the sink
    task automatic serve(input int delay);
        logic [31:0] a, d;
        wait_req();
        tick();
        repeat (delay) tick();
        a = mw_addr; d = mw_data;
        mw_ack = 1'b1;
        tick();
        mw_ack = 1'b0;
        sw_valid = 1'b1; sw_addr = a; sw_data = d;
        tick();
        sw_valid = 1'b0;
    endtask

    task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
        sw_valid = 1'b1; sw_addr = a; sw_data = d;
        tick();
        sw_valid = 1'b0;
    endtask

    task automatic clr(input logic [3:0] m);
        host_clr_we = 1'b1; host_clr_mask = m;
        tick();
        host_clr_we = 1'b0; host_clr_mask = '0;
    endtask

    task automatic rd_vec_chk(input string tag, input logic [1:0] sel, input logic [31:0] exp);
        host_rd_sel = sel;
        @(negedge clk);
        chk(tag, host_rd_vec, exp);
    endtask

    // monitor: compare each handshake against the scoreboard
    always @(negedge clk) begin
        if (rst_n && mw_req && mw_ack) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R4 unexpected write actual=%h expected=none", mw_addr);
            end else begin
                wr_t it;
                it = exp_q.pop_front();
                chk("R3 write address", mw_addr, it.a);
                chk("R3 write vector", mw_data, it.d);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mw_req", 32'(mw_req), 0);
        chk("R1 pend", 32'(host_pend), 0);
        chk("R1 ovr", 32'(host_ovr), 0);
        chk("R1 irq", 32'(host_irq), 0);

        // R5: destination still zero, event held
        cfg(1'b1, 32'hA5A5_0001);
        raise_event(CH1, 32'hA5A5_0001);
        repeat (6) tick();
        @(negedge clk);
        chk("R5 no write while dest zero", 32'(mw_req), 0);
        cfg(1'b0, CH1);            // R2 destination load releases the write
        serve(3);
        @(negedge clk);
        chk("R4 req low after ack", 32'(mw_req), 0);
        chk("R7 pend ch1", 32'(host_pend), 32'h2);
        chk("R12 irq on", 32'(host_irq), 1);
        rd_vec_chk("R7 vec ch1", 2'd1, 32'hA5A5_0001);

        // R9
        clr(4'b0001);
        @(negedge clk);
        chk("R9 other bit kept", 32'(host_pend), 32'h2);
        clr(4'b0010);
        @(negedge clk);
        chk("R9 cleared", 32'(host_pend), 0);
        chk("R12 irq off", 32'(host_irq), 0);

        // R10
        cfg(1'b1, 32'h22);
        raise_event(CH1, 32'h22);
        serve(0);
        cfg(1'b1, 32'h33);         // R2 vector load
        raise_event(CH1, 32'h33);
        serve(2);
        @(negedge clk);
        chk("R10 ovr ch1", 32'(host_ovr), 32'h2);
        chk("R10 pend ch1", 32'(host_pend), 32'h2);
        rd_vec_chk("R10 newer vector", 2'd1, 32'h33);
        clr(4'b1111);
        @(negedge clk);
        chk("R9 ovr cleared", 32'(host_ovr), 0);

        // R6: second event while the first write is outstanding
        cfg(1'b0, CH3);
        cfg(1'b1, 32'h44);
        raise_event(CH3, 32'h44);
        wait_req();
        raise_event(CH3, 32'h44);
        serve(2);
        serve(1);
        repeat (6) tick();
        @(negedge clk);
        chk("R6 no third write", 32'(mw_req), 0);
        chk("R4 scoreboard drained", 32'(exp_q.size()), 0);
        chk("R6 pend ch3", 32'(host_pend), 32'h8);
        chk("R6 ovr ch3", 32'(host_ovr), 32'h8);
        clr(4'b1111);

        // R8
        bus_wr(32'h0002_0810, 32'hDEAD);
        bus_wr(32'h0002_0802, 32'hDEAD);
        bus_wr(32'h0002_07FC, 32'hDEAD);
        bus_wr(32'h0000_0800, 32'hDEAD);
        @(negedge clk);
        chk("R8 pend untouched", 32'(host_pend), 0);
        chk("R8 ovr untouched", 32'(host_ovr), 0);
        rd_vec_chk("R8 vec ch0 untouched", 2'd0, 32'h0);

        // R7 all four channels
        bus_wr(CH0, 32'hC0);
        bus_wr(CH1, 32'hC1);
        bus_wr(CH2, 32'hC2);
        bus_wr(CH3, 32'hC3);
        @(negedge clk);
        chk("R7 pend all", 32'(host_pend), 32'hF);
        chk("R7 no ovr", 32'(host_ovr), 0);
        for (int i = 0; i < 4; i++)
            rd_vec_chk("R7 vec readback", 2'(i), 32'hC0 + 32'(i));
        clr(4'b1111);

        // R11
        bus_wr(CH2, 32'h1);
        bus_wr(CH2, 32'h2);
        @(negedge clk);
        chk("R11 setup ovr", 32'(host_ovr), 32'h4);
        sw_valid = 1'b1; sw_addr = CH2; sw_data = 32'h3;
        host_clr_we = 1'b1; host_clr_mask = 4'b0100;
        tick();
        sw_valid = 1'b0; host_clr_we = 1'b0; host_clr_mask = '0;
        @(negedge clk);
        chk("R11 pend kept", 32'(host_pend), 32'h4);
        chk("R11 ovr cleared", 32'(host_ovr), 0);
        rd_vec_chk("R11 new vector", 2'd2, 32'h3);
        clr(4'b0100);
        @(negedge clk);
        chk("R12 irq off at end", 32'(host_irq), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule